// File: doc/BRIEF.md
# Wait-State Bus Glue Controller

This block is the synchronous glue between a 16-bit-address processor with a multiplexed bank byte and its memory and I/O devices. A single fast time base clocks it. From that time base it builds the processor phase clock `ph2`. `ph2` changes level on every rising edge of the time base. When the selected device is slow, the high phase of `ph2` is held for extra cycles.

While `ph2` is low the processor places its upper address byte on the data bus. The block captures that byte on the edge that raises `ph2` and holds it for the whole high phase. The block decodes chip selects from the 16-bit address using parameterised match/mask windows, and it gates every select with the valid-address qualifiers. A dead cycle, with both qualifiers low, reaches no device. A select in a region marked slow drives the wait-state request in the same combinational path. The request is sampled only at the edge where `ph2` rises, so a request that arrives later cannot stretch the cycle in progress.

The read strobe, the write strobe and the data-bus transceiver enable are active only while `ph2` is high in a valid cycle. The device side of the bus is therefore isolated for the whole low phase. The transceiver direction follows the read/write line.

Top module: `wsbus_glue`

## Requirements
- R1: While `rst` is high (synchronous), `ph2` is 0, `bank` is 0, and every bit of `cs_n`, `wse_n`, `rd_n`, `wd_n` and `xcvr_en_n` is 1, whatever the other inputs are.
- R2: The low phase of `ph2` lasts exactly one `clk` cycle. An unstretched high phase also lasts exactly one `clk` cycle.
- R3: `bank` takes the value of `data_in` at the edge where `ph2` rises. It then holds that value while `ph2` stays high, stretch cycles included, even if `data_in` changes.
- R4: Chip select `cs_n[i]` goes low when `(addr & MASK_i) == MATCH_i` and `vda | vpa` is 1. When several windows match, only the lowest index asserts. The default windows are: bit 0 = 0xC000–0xC0FF, bit 1 = 0xE000–0xFFFF, bit 2 = 0x0000–0x7FFF. Addresses outside these windows select nothing.
- R5: When `vda` and `vpa` are both 0, every `cs_n` bit, `wse_n`, `rd_n`, `wd_n` and `xcvr_en_n` stay 1 for any address.
- R6: `wse_n` goes low combinationally in the same cycle as a chip select whose `SLOW` bit is set. By default bits 0 and 1 are slow and bit 2 is fast.
- R7: If `wse_n` is low when `ph2` rises, the high phase lasts `1 + WAIT_CYCLES` cycles. If `wse_n` goes low only after that edge, the high phase still lasts one cycle.
- R8: `rd_n` is 0 exactly when `ph2` is high, the cycle is valid and `rwb` is 1. `wd_n` is 0 exactly when `ph2` is high, the cycle is valid and `rwb` is 0. Both strobes are 1 during the low phase.
- R9: `xcvr_en_n` is 0 only while `ph2` is high in a valid cycle. `xcvr_dir` equals `rwb`, where 1 means toward the processor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global time base |
| rst | input | 1 | Synchronous reset, active high |
| vda | input | 1 | Valid data address qualifier |
| vpa | input | 1 | Valid program address qualifier |
| rwb | input | 1 | 1 = read, 0 = write |
| addr | input | AW (16) | Low address word |
| data_in | input | BW (8) | Processor data bus; carries the bank byte while ph2 is low |
| ph2 | output | 1 | Processor phase clock |
| bank | output | BW (8) | Captured bank byte |
| cs_n | output | N_CS (3) | Active-low chip selects |
| wse_n | output | 1 | Active-low wait-state request |
| rd_n | output | 1 | Active-low read strobe |
| wd_n | output | 1 | Active-low write strobe |
| xcvr_en_n | output | 1 | Active-low data transceiver enable |
| xcvr_dir | output | 1 | Transceiver direction (1 = toward processor) |

## Verification
The bench is built with `WAIT_CYCLES` = 2, so a stretched high phase (3 cycles) cannot be confused with a plain one (1 cycle). The address patterns are:
- slow I/O and ROM reads and writes;
- fast RAM accesses;
- unmapped addresses just outside a window;
- dead cycles aimed at both slow and fast addresses.

Together these separate the effects of decode, qualification and stretch. A request raised only after `ph2` rises, paired with a change of `data_in` in the same high phase, shows whether the stretch decision and the bank capture are taken at the rising edge alone. A reset applied during a stretched cycle checks that every output returns to its idle state.

// File: rtl/wsbus_glue_pkg.sv
package wsbus_glue_pkg;
   typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

   function automatic int cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/wsbus_glue_phase.sv
module wsbus_glue_phase
   import wsbus_glue_pkg::*;
#(
   parameter int WAIT_CYCLES = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic wait_req,
   output logic ph2
);
   localparam int CW = cnt_width(WAIT_CYCLES);

   phase_e ph_q;
   assign ph2 = (ph_q == PH_HIGH);

   generate
      if (WAIT_CYCLES == 0) begin : g_nostretch
         always_ff @(posedge clk) begin
            if (rst) ph_q <= PH_LOW;
            else     ph_q <= (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
         end
      end else begin : g_stretch
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               ph_q  <= PH_LOW;
               cnt_q <= '0;
            end else if (ph_q == PH_LOW) begin
               ph_q  <= PH_HIGH;
               cnt_q <= wait_req ? CW'(WAIT_CYCLES) : '0;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end else begin
               ph_q  <= PH_LOW;
            end
         end

         // R7: the stretch ends once the count has run out
         p_stretch_end_r7: assert property (@(posedge clk) disable iff (rst)
            (ph2 && cnt_q == '0) |=> !ph2);
         // R7: the count never exceeds the configured length
         p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
            cnt_q <= CW'(WAIT_CYCLES));
      end
   endgenerate

   // R2: the low phase always lasts one cycle
   p_low_single_r2: assert property (@(posedge clk) disable iff (rst)
      !ph2 |=> ph2);
endmodule

// File: rtl/wsbus_glue_decode.sv
module wsbus_glue_decode #(
   parameter int                AW    = 16,
   parameter int                N_CS  = 3,
   parameter logic [N_CS*AW-1:0] MATCH = '0,
   parameter logic [N_CS*AW-1:0] MASK  = '0,
   parameter logic [N_CS-1:0]    SLOW  = '0
) (
   input  logic [AW-1:0]   addr,
   input  logic            valid,
   output logic [N_CS-1:0] sel,
   output logic            slow_hit
);
   logic [N_CS-1:0] hit;

   for (genvar i = 0; i < N_CS; i++) begin : g_win
      assign hit[i] = ((addr & MASK[i*AW +: AW]) == MATCH[i*AW +: AW]);
   end

   always_comb begin
      logic taken;
      taken = 1'b0;
      sel   = '0;
      for (int i = 0; i < N_CS; i++) begin
         if (hit[i] && !taken && valid) begin
            sel[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end

   assign slow_hit = |(sel & SLOW);
endmodule

// File: rtl/wsbus_glue.sv
module wsbus_glue #(
   parameter int                AW          = 16,
   parameter int                BW          = 8,
   parameter int                N_CS        = 3,
   parameter int                WAIT_CYCLES = 1,
   parameter logic [N_CS*AW-1:0] CS_MATCH   = {16'h0000, 16'hE000, 16'hC000},
   parameter logic [N_CS*AW-1:0] CS_MASK    = {16'h8000, 16'hE000, 16'hFF00},
   parameter logic [N_CS-1:0]    CS_SLOW    = 3'b011
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            vda,
   input  logic            vpa,
   input  logic            rwb,
   input  logic [AW-1:0]   addr,
   input  logic [BW-1:0]   data_in,
   output logic            ph2,
   output logic [BW-1:0]   bank,
   output logic [N_CS-1:0] cs_n,
   output logic            wse_n,
   output logic            rd_n,
   output logic            wd_n,
   output logic            xcvr_en_n,
   output logic            xcvr_dir
);
   generate
      if (N_CS < 1)        begin : g_bad_ncs  $error("N_CS must be at least 1");       end
      if (AW < 1)          begin : g_bad_aw   $error("AW must be positive");           end
      if (BW < 1)          begin : g_bad_bw   $error("BW must be positive");           end
      if (WAIT_CYCLES < 0) begin : g_bad_wait $error("WAIT_CYCLES must not be negative"); end
   endgenerate

   logic            valid;
   logic [N_CS-1:0] sel;
   logic            slow_hit;
   logic            active;

   assign valid = vda | vpa;

   wsbus_glue_decode #(
      .AW(AW), .N_CS(N_CS), .MATCH(CS_MATCH), .MASK(CS_MASK), .SLOW(CS_SLOW)
   ) u_dec (
      .addr(addr), .valid(valid), .sel(sel), .slow_hit(slow_hit)
   );

   assign cs_n  = ~sel | {N_CS{rst}};
   assign wse_n = ~slow_hit | rst;

   wsbus_glue_phase #(.WAIT_CYCLES(WAIT_CYCLES)) u_ph (
      .clk(clk), .rst(rst), .wait_req(~wse_n), .ph2(ph2)
   );

   always_ff @(posedge clk) begin
      if (rst)       bank <= '0;
      else if (!ph2) bank <= data_in;
   end

   assign active    = ph2 & valid & ~rst;
   assign rd_n      = ~(active & rwb);
   assign wd_n      = ~(active & ~rwb);
   assign xcvr_en_n = ~active;
   assign xcvr_dir  = rwb;

   // R9: the transceiver opens only in the high phase
   p_xcvr_high_r9: assert property (@(posedge clk) disable iff (rst)
      !xcvr_en_n |-> ph2);
   // R5: a dead cycle selects nothing and requests no wait
   p_dead_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      !valid |-> (&cs_n && wse_n));
   // R4: at most one select at a time
   p_cs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~cs_n));
   // R6: a wait request always comes with a select
   p_wse_with_cs_r6: assert property (@(posedge clk) disable iff (rst)
      !wse_n |-> !(&cs_n));
   // R8: read and write strobes never overlap
   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> wd_n);
   // R3: the bank byte holds while ph2 is high
   p_bank_hold_r3: assert property (@(posedge clk) disable iff (rst)
      ph2 |=> $stable(bank));
endmodule

// File: tb/sim_wsbus_glue.sv
`timescale 1ns/1ps
module sim_wsbus_glue;
   localparam int W = 2;

   typedef struct packed {
      logic [15:0] a;
      logic        da;
      logic        pa;
      logic        rw;
      logic [7:0]  bk;
      logic [2:0]  cs;
      logic        ws;
      logic [3:0]  hl;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TBL [0:NV-1] = '{
      '{16'hC010, 1'b1, 1'b0, 1'b1, 8'h12, 3'b110, 1'b0, 4'd3},
      '{16'hF000, 1'b0, 1'b1, 1'b1, 8'h34, 3'b101, 1'b0, 4'd3},
      '{16'h1234, 1'b1, 1'b0, 1'b0, 8'h56, 3'b011, 1'b1, 4'd1},
      '{16'h9000, 1'b1, 1'b1, 1'b1, 8'h78, 3'b111, 1'b1, 4'd1},
      '{16'h2000, 1'b0, 1'b0, 1'b1, 8'h9A, 3'b111, 1'b1, 4'd1},
      '{16'hE000, 1'b0, 1'b0, 1'b0, 8'hAB, 3'b111, 1'b1, 4'd1},
      '{16'hC0FF, 1'b1, 1'b0, 1'b0, 8'hBC, 3'b110, 1'b0, 4'd3},
      '{16'h7FFF, 1'b1, 1'b0, 1'b1, 8'hDE, 3'b011, 1'b1, 4'd1},
      '{16'hC100, 1'b1, 1'b0, 1'b1, 8'hEF, 3'b111, 1'b1, 4'd1}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic vda = 1'b0, vpa = 1'b0, rwb = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  data_in = '0;
   logic ph2, wse_n, rd_n, wd_n, xcvr_en_n, xcvr_dir;
   logic [7:0] bank;
   logic [2:0] cs_n;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   wsbus_glue #(.WAIT_CYCLES(W)) u0 (
      .clk(clk), .rst(rst), .vda(vda), .vpa(vpa), .rwb(rwb), .addr(addr),
      .data_in(data_in), .ph2(ph2), .bank(bank), .cs_n(cs_n), .wse_n(wse_n),
      .rd_n(rd_n), .wd_n(wd_n), .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Entered at a negedge with ph2 low; returns at a negedge with ph2 low.
   task automatic run_vec(input vec_t v);
      logic vld;
      int   len;
      vld = v.da | v.pa;
      addr = v.a; vda = v.da; vpa = v.pa; rwb = v.rw; data_in = v.bk;
      #1;
      chk(cs_n == v.cs, vld ? "R4" : "R5", "cs_n", cs_n, v.cs);
      chk(wse_n == v.ws, "R6", "wse_n", wse_n, v.ws);
      chk(rd_n && wd_n && xcvr_en_n, "R8", "strobes in low phase",
          {rd_n, wd_n, xcvr_en_n}, 3'b111);
      @(negedge clk);
      len = 0;
      while (ph2 && len < 20) begin
         len++;
         chk(bank == v.bk, "R3", "bank", bank, v.bk);
         chk(rd_n == !(vld && v.rw), "R8", "rd_n", rd_n, !(vld && v.rw));
         chk(wd_n == !(vld && !v.rw), "R8", "wd_n", wd_n, !(vld && !v.rw));
         chk(xcvr_en_n == !vld, "R9", "xcvr_en_n", xcvr_en_n, !vld);
         chk(xcvr_dir == v.rw, "R9", "xcvr_dir", xcvr_dir, v.rw);
         @(negedge clk);
      end
      chk(len == int'(v.hl), (v.hl == 1) ? "R2" : "R7", "high phase length", len, v.hl);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int len;
      // R1: reset idle state, with a valid RAM address presented
      vda = 1'b1; addr = 16'h0100; data_in = 8'h5A;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ph2 == 1'b0, "R1", "ph2", ph2, 0);
      chk(bank == 8'h00, "R1", "bank", bank, 0);
      chk(cs_n == 3'b111, "R1", "cs_n", cs_n, 3'b111);
      chk({wse_n, rd_n, wd_n, xcvr_en_n} == 4'hF, "R1", "strobes",
          {wse_n, rd_n, wd_n, xcvr_en_n}, 4'hF);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) run_vec(TBL[i]);

      // R7: a request raised only after ph2 rises must not stretch;
      // R3: a data_in change during the high phase must not reach bank
      addr = 16'h1000; vda = 1'b1; vpa = 1'b0; rwb = 1'b1; data_in = 8'h3C;
      @(negedge clk);
      chk(ph2 == 1'b1, "R2", "ph2 after low", ph2, 1);
      addr = 16'hE000; data_in = 8'hC3;
      #1;
      chk(wse_n == 1'b0, "R6", "late wse_n", wse_n, 0);
      len = 0;
      while (ph2 && len < 20) begin
         len++;
         chk(bank == 8'h3C, "R3", "bank hold", bank, 8'h3C);
         @(negedge clk);
      end
      chk(len == 1, "R7", "late request length", len, 1);

      // R1: reset applied during a stretched cycle
      addr = 16'hC020; vda = 1'b1; rwb = 1'b1; data_in = 8'h77;
      @(negedge clk);
      chk(ph2 == 1'b1, "R7", "ph2 in slow cycle", ph2, 1);
      rst = 1'b1;
      @(negedge clk);
      chk(ph2 == 1'b0, "R1", "ph2 after mid reset", ph2, 0);
      chk(bank == 8'h00, "R1", "bank after mid reset", bank, 0);
      chk(cs_n == 3'b111, "R1", "cs_n after mid reset", cs_n, 3'b111);
      chk({wse_n, rd_n, wd_n, xcvr_en_n} == 4'hF, "R1", "strobes after mid reset",
          {wse_n, rd_n, wd_n, xcvr_en_n}, 4'hF);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule